// File: doc/BRIEF.md
# Multidrop Address-Wakeup Serial Receiver

This block is the receive half of an asynchronous serial port for a shared bus with many stations. Every character on the line carries a ninth bit that marks it as a station address (1) or as payload data (0). With the multidrop mode bit clear, the block is an ordinary receiver: it accepts every character while enabled and drops every character while disabled.

With the multidrop mode bit set, a disabled receiver keeps decoding the line. Address characters are captured and flagged, and can raise an interrupt. Data characters are dropped. Software reads the captured address, compares it with its own station number and turns the receiver on for the data block that follows. Later it turns the receiver off again and waits for the next address. Address matching is left to software, so any of 256 station numbers can be used.

The block contains the input synchronizer, start-bit qualification with 16x oversampling, the character shift register, the address flag and a single-character holding register with status. The oversampling tick comes from outside.

Top module: `mdrop_rx`

## Requirements
- R1: A frame has one low start bit, 8 data bits sent least significant bit first, one address flag bit (1 = address, 0 = data) and one high stop bit. Each bit lasts 16 `os_tick` pulses. With `os_tick` held high, the held character and all status outputs update on the clock edge that comes 171 edges after the first edge at which the start bit is present on `rxd`.
- R2: A low level on `rxd` that is high again at the middle of the start bit is rejected and produces no character.
- R3: With `multidrop_en` low, the receiver accepts every character while `rx_enable` is high and discards every character while `rx_enable` is low.
- R4: With `multidrop_en` high and `rx_enable` low, a character whose flag bit is 1 is accepted: `rx_byte` holds its 8 bits, and `rx_ready` and `rx_is_addr` go to 1.
- R5: With `multidrop_en` high and `rx_enable` low, a character whose flag bit is 0 changes none of the outputs.
- R6: While `rx_enable` is high, every character is accepted, and `rx_is_addr` reports the flag bit of the character being held.
- R7: `irq` is high exactly when `rx_ready` is high and `irq_en` was high at the clock edge that produced this state.
- R8: A stop bit sampled low sets `frame_err` for the accepted character. A stop bit sampled high clears it.
- R9: A character accepted while `rx_ready` is still high, and not read in the same cycle, sets `overrun` and leaves the held character and its flags unchanged.
- R10: `rd_strobe` clears `rx_ready`, `frame_err` and `overrun`. If a new character is accepted in the same cycle, the new character is loaded, `rx_ready` stays high and no overrun is flagged.
- R11: After reset, `rx_ready`, `rx_is_addr`, `frame_err`, `overrun` and `irq` are 0 and `rx_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| multidrop_en | input | 1 | Address-wakeup mode select |
| rx_enable | input | 1 | Receiver enable from software |
| irq_en | input | 1 | Interrupt enable for the ready flag |
| rd_strobe | input | 1 | One-cycle read of the held character |
| rx_byte | output | 8 | Held character |
| rx_ready | output | 1 | A character is waiting |
| rx_is_addr | output | 1 | Flag bit of the held character |
| frame_err | output | 1 | Held character had a low stop bit |
| overrun | output | 1 | A character arrived while one was waiting |
| irq | output | 1 | Ready interrupt |

## Verification
Two things can happen in the same clock cycle: a character completes, and the CPU read strobe clears the holding register. The bench schedules `rd_strobe` on the exact edge at which a frame lands, once while the ready flag is set and once while the frame is a rejected data character. A behavioural model applies the read first and the arrival second, and it is compared with every output on every clock. The case passes only if the new byte is loaded, ready stays high and overrun stays low, or, for the rejected data character, if the read alone takes effect.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_FLAG  = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_t;

  localparam int unsigned DEF_CHAR_W = 8;
  localparam int unsigned DEF_OSR    = 16;
  localparam int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mdrop_rx_frame.sv
module mdrop_rx_frame
  import mdrop_rx_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  output logic              done,
  output logic [CHAR_W-1:0] ch_bits,
  output logic              ch_flag,
  output logic              ch_stop_ok
);
  localparam int unsigned CW   = $clog2(OSR);
  localparam int unsigned BW   = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] TOPB = BW'(CHAR_W - 1);

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [CHAR_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bitn       <= '0;
      shreg      <= '0;
      done       <= 1'b0;
      ch_flag    <= 1'b0;
      ch_stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!line) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID) begin
              cnt  <= '0;
              bitn <= '0;
              state <= line ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              shreg <= {line, shreg[CHAR_W-1:1]};
              if (bitn == TOPB) state <= ST_FLAG;
              else              bitn  <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_FLAG: begin
            if (cnt == LAST) begin
              cnt     <= '0;
              ch_flag <= line;
              state   <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == LAST) begin
              cnt        <= '0;
              ch_stop_ok <= line;
              done       <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign ch_bits = shreg;

  // R1: a completed frame is reported for one cycle only
  assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: the start bit is only qualified when it is still low
  assert_start_qualified_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && tick && cnt == MID && line) |=> state == ST_IDLE);
endmodule

// File: rtl/mdrop_rx_hold.sv
module mdrop_rx_hold #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [CHAR_W-1:0] ch_bits,
  input  logic              ch_flag,
  input  logic              ch_stop_ok,
  input  logic              multidrop_en,
  input  logic              rx_enable,
  input  logic              irq_en,
  input  logic              rd_strobe,
  output logic [CHAR_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              rx_is_addr,
  output logic              frame_err,
  output logic              overrun,
  output logic              irq
);
  logic              take;
  logic              ready_n, addr_n, ferr_n, ovr_n;
  logic [CHAR_W-1:0] byte_n;

  assign take = done && (rx_enable || (multidrop_en && ch_flag));

  always_comb begin
    byte_n  = rx_byte;
    addr_n  = rx_is_addr;
    ready_n = rx_ready;
    ferr_n  = frame_err;
    ovr_n   = overrun;
    if (rd_strobe) begin
      ready_n = 1'b0;
      ferr_n  = 1'b0;
      ovr_n   = 1'b0;
    end
    if (take) begin
      if (ready_n) begin
        ovr_n = 1'b1;
      end else begin
        byte_n  = ch_bits;
        addr_n  = ch_flag;
        ferr_n  = !ch_stop_ok;
        ready_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte    <= '0;
      rx_is_addr <= 1'b0;
      rx_ready   <= 1'b0;
      frame_err  <= 1'b0;
      overrun    <= 1'b0;
      irq        <= 1'b0;
    end else begin
      rx_byte    <= byte_n;
      rx_is_addr <= addr_n;
      rx_ready   <= ready_n;
      frame_err  <= ferr_n;
      overrun    <= ovr_n;
      irq        <= ready_n && irq_en;
    end
  end

  // R5: a data character seen while disabled in multidrop mode leaves the holding register alone
  assert_data_dropped_R5: assert property (@(posedge clk) disable iff (rst)
    (done && multidrop_en && !rx_enable && !ch_flag && !rd_strobe)
      |=> ($stable(rx_ready) && $stable(rx_byte) && $stable(overrun)));

  // R9: an unread character is never overwritten
  assert_overrun_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (take && rx_ready && !rd_strobe) |=> (overrun && $stable(rx_byte) && $stable(rx_is_addr)));

  // R10: a read with no arrival empties the holding register
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !take) |=> (!rx_ready && !overrun && !frame_err));

  // R7: the interrupt only signals a waiting character
  assert_irq_needs_ready_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> rx_ready);

  // R8: framing status only describes a held character
  assert_ferr_with_ready_R8: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> rx_ready);
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int unsigned CHAR_W = DEF_CHAR_W,
  parameter int unsigned OSR    = DEF_OSR,
  parameter int unsigned SYNC   = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              multidrop_en,
  input  logic              rx_enable,
  input  logic              irq_en,
  input  logic              rd_strobe,
  output logic [CHAR_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              rx_is_addr,
  output logic              frame_err,
  output logic              overrun,
  output logic              irq
);
  logic              line_s;
  logic              f_done, f_flag, f_stop_ok;
  logic [CHAR_W-1:0] f_bits;

  mdrop_rx_sync #(.STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (line_s)
  );

  mdrop_rx_frame #(.CHAR_W(CHAR_W), .OSR(OSR)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .tick       (os_tick),
    .line       (line_s),
    .done       (f_done),
    .ch_bits    (f_bits),
    .ch_flag    (f_flag),
    .ch_stop_ok (f_stop_ok)
  );

  mdrop_rx_hold #(.CHAR_W(CHAR_W)) u_hold (
    .clk          (clk),
    .rst          (rst),
    .done         (f_done),
    .ch_bits      (f_bits),
    .ch_flag      (f_flag),
    .ch_stop_ok   (f_stop_ok),
    .multidrop_en (multidrop_en),
    .rx_enable    (rx_enable),
    .irq_en       (irq_en),
    .rd_strobe    (rd_strobe),
    .rx_byte      (rx_byte),
    .rx_ready     (rx_ready),
    .rx_is_addr   (rx_is_addr),
    .frame_err    (frame_err),
    .overrun      (overrun),
    .irq          (irq)
  );

  // R3: normal mode with the receiver off never produces a character
  assert_normal_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!multidrop_en && !rx_enable && !rx_ready) |=> !rx_ready);
endmodule

// File: tb/mdrop_rx_test.sv
module mdrop_rx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b1;
  logic       rxd = 1'b1;
  logic       multidrop_en = 1'b0;
  logic       rx_enable = 1'b0;
  logic       irq_en = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_ready, rx_is_addr, frame_err, overrun, irq;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  // reference model state
  int         cyc = 0;
  int         stamp = -1000;
  logic [7:0] p_byte = 8'h00;
  logic       p_flag = 1'b0;
  logic       p_stop = 1'b1;
  logic [7:0] m_byte = 8'h00;
  logic       m_ready = 1'b0, m_addr = 1'b0, m_ferr = 1'b0, m_ovr = 1'b0, m_irq = 1'b0;

  always #2 clk = ~clk;

  mdrop_rx uut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
    .multidrop_en(multidrop_en), .rx_enable(rx_enable), .irq_en(irq_en),
    .rd_strobe(rd_strobe), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .rx_is_addr(rx_is_addr), .frame_err(frame_err), .overrun(overrun), .irq(irq)
  );

  // behavioural model: frame lands 171 edges after the start bit is driven (R1)
  always @(posedge clk) begin
    if (rst) begin
      m_byte = 8'h00; m_ready = 0; m_addr = 0; m_ferr = 0; m_ovr = 0; m_irq = 0;
    end else begin
      if (rd_strobe) begin
        m_ready = 0; m_ferr = 0; m_ovr = 0;
      end
      if (cyc == stamp + 171) begin
        if (rx_enable || (multidrop_en && p_flag)) begin
          if (m_ready) m_ovr = 1;
          else begin
            m_byte = p_byte; m_addr = p_flag; m_ferr = !p_stop; m_ready = 1;
          end
        end
      end
      m_irq = m_ready && irq_en;
    end
    cyc = cyc + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done_run) begin
      chk("R1/R4/R6 rx_byte", rx_byte, m_byte);
      chk("R3/R5 rx_ready", rx_ready, m_ready);
      chk("R6 rx_is_addr", rx_is_addr, m_addr);
      chk("R8 frame_err", frame_err, m_ferr);
      chk("R9 overrun", overrun, m_ovr);
      chk("R7 irq", irq, m_irq);
    end
  end

  task automatic send(input logic [7:0] b, input logic f, input logic s, input int rd_at);
    logic [10:0] bits;
    bits = {s, f, b, 1'b0};
    @(negedge clk);
    p_byte = b; p_flag = f; p_stop = s; stamp = cyc;
    for (int n = 0; n < 176; n++) begin
      if (n > 0) @(negedge clk);
      rxd = bits[n/16];
      if (rd_at != 0 && n == 171) rd_strobe = 1'b1;
      if (rd_at != 0 && n == 172) rd_strobe = 1'b0;
    end
    @(negedge clk);
    rxd = 1'b1;
    rd_strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    chk("R11 reset ready", rx_ready, 0);
    chk("R11 reset irq", irq, 0);
    @(negedge clk); rst = 1'b0;
    idle(3);
    chk("R11 post-reset byte", rx_byte, 0);

    // R3: normal mode, enabled then disabled
    rx_enable = 1; irq_en = 1;
    send(8'hA5, 1'b0, 1'b1, 0); idle(4);
    chk("R3 normal accepted", rx_byte, 8'hA5);
    chk("R7 irq raised", irq, 1);
    do_read(); idle(2);
    chk("R10 read clears", rx_ready, 0);
    rx_enable = 0;
    send(8'h3C, 1'b1, 1'b1, 0); idle(4);
    chk("R3 normal disabled drops", rx_ready, 0);

    // R2: short glitch is rejected
    @(negedge clk); rxd = 0; idle(4); rxd = 1; idle(40);
    chk("R2 glitch ignored", rx_ready, 0);

    // multidrop, receiver off
    multidrop_en = 1;
    send(8'h11, 1'b0, 1'b1, 0); idle(4);
    chk("R5 data dropped", rx_ready, 0);
    send(8'h5A, 1'b1, 1'b1, 0); idle(4);
    chk("R4 address byte", rx_byte, 8'h5A);
    chk("R4 address flag", rx_is_addr, 1);
    chk("R4 irq on address", irq, 1);
    // R5 data while ready held and a coincident read: only the read acts
    send(8'h22, 1'b0, 1'b1, 1); idle(4);
    chk("R5 data + read", rx_ready, 0);

    // software enables receiver for the block
    rx_enable = 1; irq_en = 0;
    send(8'h81, 1'b0, 1'b1, 0); idle(4);
    chk("R6 data accepted", rx_byte, 8'h81);
    chk("R6 flag is data", rx_is_addr, 0);
    chk("R7 irq masked", irq, 0);
    // R9 overrun
    send(8'h7E, 1'b1, 1'b1, 0); idle(4);
    chk("R9 overrun set", overrun, 1);
    chk("R9 old byte kept", rx_byte, 8'h81);
    // R10 coincident read and arrival
    send(8'hC3, 1'b1, 1'b1, 1); idle(4);
    chk("R10 new byte loaded", rx_byte, 8'hC3);
    chk("R10 ready stays", rx_ready, 1);
    chk("R10 no overrun", overrun, 0);
    do_read(); idle(2);

    // R8 framing error, then a clean frame clears it
    irq_en = 1;
    send(8'h0F, 1'b0, 1'b0, 0); idle(24);
    chk("R8 ferr set", frame_err, 1);
    do_read(); idle(2);
    send(8'hF0, 1'b0, 1'b1, 0); idle(4);
    chk("R8 ferr clear", frame_err, 0);
    chk("R1 lsb first", rx_byte, 8'hF0);
    rx_enable = 0;
    do_read(); idle(4);

    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule